// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Holding Register and Status Flags

This block turns an asynchronous serial line into bytes a CPU can read. A sampler watches the line on a 16x oversampling tick supplied from outside. It locates each start bit and collects eight data bits, least significant first. When the mode input asks for it, it also collects a ninth bit that marks an address character. It then checks the stop bit. Each finished character is written into a four-entry queue, together with one flag bit. The flag bit is the ninth bit or-ed with a framing error. The queue feeds a one-byte holding register, which is the receive data register the CPU reads.

The CPU reaches the block through a small read port with two locations: the holding register and a status byte. The status byte shows:
- receive ready,
- the address/framing flag of the held character,
- overrun.

An interrupt request flip-flop is set each time a character enters the holding register and is cleared by a data read. If more characters are queued, the read reloads the holding register at once and the request sets again in the same step. Software must therefore read the status flag before it reads the data byte. The line input is taken to be already synchronous to `clk`.

Top module: `srx_top`

## Requirements
- R1: After reset the status byte reads 0x00 and `rx_irq` is low.
- R2: A frame is a low start bit, eight data bits (LSB first), a ninth bit only while `ninth_en` is 1, and a stop bit. Each bit lasts 16 `tick16` pulses and is sampled on the 8th pulse of its bit time, counting the pulse that found the start edge as the 1st. The received byte reads back at `bus_addr`=0.
- R3: If the line is high again at the start bit's sample point, the start is false: nothing is received and the status is unchanged.
- R4: Status bit 7 is 1 exactly while the holding register holds an unread character.
- R5: Status bit 6 is 1 when the held character's ninth bit was 1 or its stop bit was sampled low. A break (all-zero data with a low stop bit) therefore reads as data 0x00 with bit 6 set.
- R6: Up to five characters are kept (holding register plus four queue entries) and are delivered in arrival order.
- R7: A character that completes while the queue and the holding register are both full is discarded and sets status bit 5. A data read clears bit 5.
- R8: `rx_irq` sets when a character is loaded into the holding register. A data read clears it, unless another character is queued: then that character loads on the read and `rx_irq` stays high.
- R9: Status bits 4 down to 0 always read 0.
- R10: Reading the status location (`bus_addr`=1) changes no state.
- R11: A data read while the holding register is empty leaves the status at 0x00 and `rx_irq` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | Oversampling enable, 16 pulses per bit time |
| rxd | input | 1 | Serial line, idle high |
| ninth_en | input | 1 | 1: frames carry a ninth (address) bit |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_addr | input | 1 | 0: holding register, 1: status byte |
| bus_rdata | output | 8 | Read data, valid while `bus_rd` is high |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
Single frames are sent first:
- plain 8-bit data, which shows the bit order and sample point;
- ninth-bit frames with the address bit set and then cleared, which separates the address flag from the data;
- a break with a low stop bit, which shows that a framing error is reported through the same flag.

A short low glitch tests false-start rejection. A burst of six frames with no reads fills the holding register and all four queue entries and then overruns. Draining that burst shows arrival order, that overrun clears on a data read, and that the interrupt re-arms on every read while characters remain. Status reads between data reads show that status access changes nothing. A data read of an empty receiver shows that such a read has no effect.

// File: rtl/srx_pkg.sv
package srx_pkg;
  localparam int unsigned SRX_DATA_W = 8;
  localparam int unsigned SRX_OSR    = 16;
  localparam int unsigned SRX_DEPTH  = 4;

  typedef enum logic [2:0] {
    SR_IDLE  = 3'd0,
    SR_START = 3'd1,
    SR_DATA  = 3'd2,
    SR_NINTH = 3'd3,
    SR_STOP  = 3'd4
  } srx_state_e;
endpackage

// File: rtl/srx_bit_sampler.sv
module srx_bit_sampler
  import srx_pkg::*;
#(
  parameter int unsigned OSR    = SRX_OSR,
  parameter int unsigned DATA_W = SRX_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rxd,
  input  logic              ninth_en,
  output logic              chr_vld,
  output logic [DATA_W:0]   chr_word
);
  localparam int unsigned CW = $clog2(OSR);
  localparam int unsigned BW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CW-1:0] MID   = CW'(OSR/2 - 1);
  localparam logic [CW-1:0] LAST  = CW'(OSR - 1);
  localparam logic [CW-1:0] ONE   = CW'(1);
  localparam logic [BW-1:0] BLAST = BW'(DATA_W - 1);

  srx_state_e        st_q, st_n;
  logic [CW-1:0]     cnt_q, cnt_n;
  logic [BW-1:0]     bidx_q, bidx_n;
  logic [DATA_W-1:0] shf_q, shf_n;
  logic              nin_q, nin_n;
  logic              vld_q, vld_n;
  logic [DATA_W:0]   word_q, word_n;
  logic              at_mid, at_last;

  assign at_mid  = (cnt_q == MID);
  assign at_last = (cnt_q == LAST);

  always_comb begin
    st_n   = st_q;
    cnt_n  = cnt_q;
    bidx_n = bidx_q;
    shf_n  = shf_q;
    nin_n  = nin_q;
    vld_n  = 1'b0;
    word_n = word_q;
    if (tick) begin
      if (st_q == SR_IDLE) begin
        if (!rxd) begin
          st_n  = SR_START;
          cnt_n = ONE;
        end
      end else begin
        cnt_n = at_last ? '0 : cnt_q + ONE;
        case (st_q)
          SR_START: begin
            if (at_mid && rxd) begin
              st_n = SR_IDLE;
            end else if (at_last) begin
              st_n   = SR_DATA;
              bidx_n = '0;
              nin_n  = 1'b0;
            end
          end
          SR_DATA: begin
            if (at_mid) shf_n = {rxd, shf_q[DATA_W-1:1]};
            if (at_last) begin
              if (bidx_q == BLAST) st_n = ninth_en ? SR_NINTH : SR_STOP;
              else                 bidx_n = bidx_q + 1'b1;
            end
          end
          SR_NINTH: begin
            if (at_mid)  nin_n = rxd;
            if (at_last) st_n  = SR_STOP;
          end
          SR_STOP: begin
            if (at_mid) begin
              vld_n  = 1'b1;
              word_n = {nin_q | ~rxd, shf_q};
              st_n   = SR_IDLE;
            end
          end
          default: st_n = SR_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SR_IDLE;
      cnt_q  <= '0;
      bidx_q <= '0;
      shf_q  <= '0;
      nin_q  <= 1'b0;
      vld_q  <= 1'b0;
      word_q <= '0;
    end else begin
      st_q   <= st_n;
      cnt_q  <= cnt_n;
      bidx_q <= bidx_n;
      shf_q  <= shf_n;
      nin_q  <= nin_n;
      vld_q  <= vld_n;
      word_q <= word_n;
    end
  end

  assign chr_vld  = vld_q;
  assign chr_word = word_q;

  // R2
  vld_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chr_vld |=> !chr_vld);

  // R3
  false_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SR_START && tick && at_mid && rxd) |=> (st_q == SR_IDLE && !chr_vld));
endmodule

// File: rtl/srx_fifo.sv
module srx_fifo #(
  parameter int unsigned W     = 9,
  parameter int unsigned DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNTW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0]   PLAST = AW'(DEPTH - 1);
  localparam logic [CNTW-1:0] CFULL = CNTW'(DEPTH);

  logic [W-1:0]    mem [DEPTH];
  logic [AW-1:0]   wp_q, wp_n, rp_q, rp_n;
  logic [CNTW-1:0] cnt_q, cnt_n;

  always_comb begin
    wp_n  = wp_q;
    rp_n  = rp_q;
    cnt_n = cnt_q;
    if (push) wp_n = (wp_q == PLAST) ? '0 : wp_q + 1'b1;
    if (pop)  rp_n = (rp_q == PLAST) ? '0 : rp_q + 1'b1;
    case ({push, pop})
      2'b10:   cnt_n = cnt_q + 1'b1;
      2'b01:   cnt_n = cnt_q - 1'b1;
      default: cnt_n = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_n;
      rp_q  <= rp_n;
      cnt_q <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp_q] <= din;
  end

  assign dout  = mem[rp_q];
  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CFULL);

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (!full || pop));

  // R6
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/srx_hold_status.sv
module srx_hold_status #(
  parameter int unsigned DATA_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            chr_vld,
  input  logic            fifo_empty,
  input  logic            fifo_full,
  input  logic [DATA_W:0] fifo_dout,
  input  logic            rd_data,
  output logic            fifo_push,
  output logic            fifo_pop,
  output logic            hold_full,
  output logic [DATA_W:0] hold_word,
  output logic            ovr,
  output logic            irq
);
  logic            full_q, full_n;
  logic [DATA_W:0] word_q, word_n;
  logic            ovr_q, ovr_n;
  logic            irq_q, irq_n;
  logic            ovr_set;

  assign fifo_pop  = !fifo_empty && (!full_q || rd_data);
  assign fifo_push = chr_vld && (!fifo_full || fifo_pop);
  assign ovr_set   = chr_vld && !fifo_push;

  always_comb begin
    full_n = full_q;
    word_n = word_q;
    irq_n  = irq_q;
    ovr_n  = ovr_q;
    if (fifo_pop) begin
      full_n = 1'b1;
      word_n = fifo_dout;
      irq_n  = 1'b1;
    end else if (rd_data) begin
      full_n = 1'b0;
      irq_n  = 1'b0;
    end
    if (ovr_set)      ovr_n = 1'b1;
    else if (rd_data) ovr_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      word_q <= '0;
      ovr_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      full_q <= full_n;
      word_q <= word_n;
      ovr_q  <= ovr_n;
      irq_q  <= irq_n;
    end
  end

  assign hold_full = full_q;
  assign hold_word = word_q;
  assign ovr       = ovr_q;
  assign irq       = irq_q;

  // R8
  rearm_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && !fifo_empty) |=> (hold_full && irq));

  // R8
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && fifo_empty) |=> (!irq && !hold_full));

  // R7
  ovr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr) |-> $past(chr_vld && fifo_full && hold_full));

  // R7
  ovr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && !chr_vld) |=> !ovr);

  // R4
  irq_needs_char_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> hold_full);
endmodule

// File: rtl/srx_top.sv
module srx_top
  import srx_pkg::*;
#(
  parameter int unsigned OSR    = SRX_OSR,
  parameter int unsigned DATA_W = SRX_DATA_W,
  parameter int unsigned DEPTH  = SRX_DEPTH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick16,
  input  logic              rxd,
  input  logic              ninth_en,
  input  logic              bus_rd,
  input  logic              bus_addr,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              rx_irq
);
  localparam int unsigned WW = DATA_W + 1;

  logic          chr_vld;
  logic [WW-1:0] chr_word;
  logic          f_push, f_pop, f_empty, f_full;
  logic [WW-1:0] f_dout;
  logic          hold_full, ovr, irq;
  logic [WW-1:0] hold_word;
  logic          rd_data;
  logic [DATA_W-1:0] status;

  assign rd_data = bus_rd && !bus_addr;

  srx_bit_sampler #(.OSR(OSR), .DATA_W(DATA_W)) sampler_i (
    .clk(clk), .rst_n(rst_n), .tick(tick16), .rxd(rxd), .ninth_en(ninth_en),
    .chr_vld(chr_vld), .chr_word(chr_word)
  );

  srx_fifo #(.W(WW), .DEPTH(DEPTH)) queue_i (
    .clk(clk), .rst_n(rst_n), .push(f_push), .din(chr_word), .pop(f_pop),
    .dout(f_dout), .empty(f_empty), .full(f_full)
  );

  srx_hold_status #(.DATA_W(DATA_W)) hold_i (
    .clk(clk), .rst_n(rst_n), .chr_vld(chr_vld), .fifo_empty(f_empty),
    .fifo_full(f_full), .fifo_dout(f_dout), .rd_data(rd_data),
    .fifo_push(f_push), .fifo_pop(f_pop), .hold_full(hold_full),
    .hold_word(hold_word), .ovr(ovr), .irq(irq)
  );

  always_comb begin
    status = '0;
    status[DATA_W-1] = hold_full;
    status[DATA_W-2] = hold_full & hold_word[DATA_W];
    status[DATA_W-3] = ovr;
  end

  assign bus_rdata = bus_addr ? status : hold_word[DATA_W-1:0];
  assign rx_irq    = irq;

  // R10
  status_read_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr && !f_push && !f_pop) |=> ($stable(hold_full) && $stable(ovr) && $stable(rx_irq)));
endmodule

// File: tb/srx_top_tb_top.sv
`timescale 1ns/1ps
module srx_top_tb_top;
  logic       clk, rst_n, tick16, rxd, ninth_en, bus_rd, bus_addr;
  logic [7:0] bus_rdata;
  logic       rx_irq;

  int n_chk = 0;
  int n_fail = 0;
  bit settled = 0;
  bit done = 0;

  logic [8:0] mq[$];
  bit         m_ovr = 0;

  srx_top dut_i (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd), .ninth_en(ninth_en),
    .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_rdata(bus_rdata), .rx_irq(rx_irq)
  );

  initial clk = 0;
  always #4 clk = ~clk;

  initial begin
    tick16 = 0;
    forever begin
      @(negedge clk);
      tick16 = ~tick16;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_status();
    logic [7:0] s;
    s = 8'h00;
    if (mq.size() > 0) begin
      s[7] = 1'b1;
      s[6] = mq[0][8];
    end
    s[5] = m_ovr;
    return s;
  endfunction

  // R8: interrupt compared against the model on every settled clock
  always @(negedge clk) begin
    if (settled && rst_n && !done) check("R8 irq", rx_irq, (mq.size() > 0));
  end

  task automatic drive_bit(input logic v, input int cyc);
    rxd = v;
    repeat (cyc) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input logic nine, input bit stop_ok);
    settled = 0;
    @(negedge clk);
    drive_bit(1'b0, 32);
    for (int i = 0; i < 8; i++) drive_bit(d[i], 32);
    if (ninth_en) drive_bit(nine, 32);
    if (stop_ok) begin
      drive_bit(1'b1, 32);
    end else begin
      drive_bit(1'b0, 18);
      drive_bit(1'b1, 40);
    end
    if (mq.size() < 5) mq.push_back({(ninth_en & nine) | ~stop_ok, d});
    else m_ovr = 1;
    repeat (4) @(negedge clk);
    settled = 1;
  endtask

  task automatic read_status(input string req);
    @(negedge clk);
    bus_rd = 1; bus_addr = 1;
    #1 check(req, bus_rdata, exp_status());
    @(posedge clk);
    @(negedge clk);
    bus_rd = 0;
  endtask

  task automatic read_data(input string req);
    logic [8:0] head;
    bit had;
    @(negedge clk);
    bus_rd = 1; bus_addr = 0;
    had = (mq.size() > 0);
    if (had) begin
      head = mq[0];
      #1 check(req, bus_rdata, head[7:0]);
    end
    @(posedge clk);
    #1;
    if (had) void'(mq.pop_front());
    m_ovr = 0;
    @(negedge clk);
    bus_rd = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 0; rxd = 1; ninth_en = 0; bus_rd = 0; bus_addr = 0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    settled = 1;
    // R1 reset state
    check("R1 irq", rx_irq, 0);
    read_status("R1 status");

    // R2/R4 plain byte
    send_frame(8'hA5, 1'b0, 1);
    read_status("R4 status ready");
    read_status("R9 status low bits zero");
    read_data("R2 data A5");
    read_status("R4 status empty");

    // R5 ninth bit
    ninth_en = 1;
    send_frame(8'h3C, 1'b1, 1);
    read_status("R5 address flag set");
    read_data("R5 data 3C");
    send_frame(8'h81, 1'b0, 1);
    read_status("R5 address flag clear");
    read_data("R2 data 81");
    ninth_en = 0;

    // R5 break
    send_frame(8'h00, 1'b0, 0);
    read_status("R5 break flag");
    read_data("R5 break data");
    read_status("R3 no char after break");

    // R3 false start
    settled = 0;
    @(negedge clk);
    drive_bit(1'b0, 8);
    drive_bit(1'b1, 60);
    settled = 1;
    read_status("R3 false start");

    // R6/R7 fill and overrun
    send_frame(8'h11, 1'b0, 1);
    send_frame(8'h22, 1'b0, 1);
    send_frame(8'h33, 1'b0, 0);
    send_frame(8'h44, 1'b0, 1);
    send_frame(8'h55, 1'b0, 1);
    read_status("R6 full no overrun");
    send_frame(8'h66, 1'b0, 1);
    read_status("R7 overrun set");
    read_status("R10 status read repeat");
    read_data("R6 order 11");
    read_status("R7 overrun cleared");
    check("R8 irq rearm", rx_irq, 1);
    read_data("R6 order 22");
    read_status("R5 framing in queue");
    read_data("R6 order 33");
    read_data("R6 order 44");
    read_data("R6 order 55");
    read_status("R7 discarded char absent");
    check("R8 irq cleared", rx_irq, 0);

    // R11 empty read
    read_data("R11 empty read");
    read_status("R11 status after empty read");
    check("R11 irq", rx_irq, 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule